// File: doc/BRIEF.md
# Test access port with configuration register access

This block is a serial test access port controller with a 4-bit instruction register. Besides the usual boundary-scan, identification and bypass instructions, it gives a tester byte-wide access to an on-chip configuration register file. An address register can be loaded by scan, and every byte read or written moves that address on by one. Two more instructions ask the surrounding logic to copy the register file to non-volatile storage or to fetch it back again.

Everything runs on the test clock. The register-file port is a plain address, write-data, write-strobe and read-data interface that the file answers combinationally. Save and restore requests are single-cycle strobes. While the storage engine reports busy, the port refuses new programming instructions and falls back to the one-bit bypass path. Boundary cells live outside the block; the port only steers them and routes their serial output.

Top module: `jtag_cfg_tap`

## Requirements
- R1: With trst_n low or jtag_mode low the controller is held in Test-Logic-Reset asynchronously, the instruction becomes IDCODE (0010), the register-file address becomes 0 and TDO is not driven; leaving reset keeps Test-Logic-Reset while TMS is high.
- R2: Five consecutive rising TCK edges with TMS high bring the controller to Test-Logic-Reset from any state, and the instruction becomes IDCODE.
- R3: Instruction codes: 0000 EXTEST, 0001 SAMPLE, 0010 IDCODE, 0011 set-address, 0100 write-byte, 0101 read-byte, 0110 save, 0111 restore, 1000 CLAMP, 1001 HIGHZ, 1111 BYPASS. Capture-IR loads 0001, the instruction shifts in LSB first and takes effect in Update-IR.
- R4: Under IDCODE, Capture-DR loads the 32-bit IDCODE parameter, shifted out LSB first.
- R5: Under set-address, an ADDR_W-bit register is scanned; Capture-DR loads the current address and Update-DR makes the scanned value the new address. Only trst_n or jtag_mode clear the address.
- R6: Under write-byte, an 8-bit register is scanned; rf_we is high for the Update-DR state cycle with rf_wdata holding the scanned byte and rf_addr the target.
- R7: Under read-byte, Capture-DR loads rf_rdata for the current rf_addr, shifted out LSB first.
- R8: Each Update-DR under write-byte or read-byte advances the address by one, wrapping from 2^ADDR_W-1 to 0.
- R9: Loading save (restore) raises save_req (restore_req) for the Update-IR state cycle only; both select the one-bit bypass path.
- R10: If busy is high in Update-IR and the shifted code is 0100 to 0111, the instruction becomes BYPASS (1111) and no request is raised; other codes load normally while busy.
- R11: BYPASS, CLAMP, HIGHZ, save, restore and all unlisted codes scan a one-bit register that captures 0.
- R12: EXTEST and SAMPLE route bs_so to TDO and drive bs_capture, bs_shift and bs_update in Capture-DR, Shift-DR and Update-DR; pins_drive is high under EXTEST or CLAMP, pins_hiz under HIGHZ.
- R13: TDO changes on the falling TCK edge, is driven (tdo_en high) only in Shift-IR and Shift-DR, and is high impedance otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| jtag_mode | input | 1 | Port enable; low holds the controller in reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, high impedance when idle |
| tdo_en | output | 1 | TDO drive enable |
| rf_addr | output | ADDR_W | Register-file address |
| rf_wdata | output | DATA_W | Register-file write data |
| rf_we | output | 1 | Register-file write strobe |
| rf_rdata | input | DATA_W | Register-file read data for rf_addr |
| save_req | output | 1 | Request to store the register file |
| restore_req | output | 1 | Request to reload the register file |
| busy | input | 1 | Store or reload in progress |
| bs_so | input | 1 | Serial output of the boundary chain |
| bs_capture | output | 1 | Boundary chain capture strobe |
| bs_shift | output | 1 | Boundary chain shift enable |
| bs_update | output | 1 | Boundary chain update strobe |
| pins_drive | output | 1 | Pins driven from boundary cells |
| pins_hiz | output | 1 | Pins forced to high impedance |

## Verification
The bench builds the port with ADDR_W of 4, DATA_W of 8 and a nonzero IDCODE whose low bit is set. The four-bit address makes the wrap from 15 to 0 reachable with a handful of byte scans, and the small file lets the bench compare every location against its model at the end. The IDCODE pattern is asymmetric, so a reversed or shortened shift shows up in a single scan.

// File: rtl/jtag_cfg_pkg.sv
`timescale 1ns/1ps
package jtag_cfg_pkg;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,  ST_SELDR, ST_CAPDR, ST_SHDR, ST_EX1DR, ST_PAUDR, ST_EX2DR,
    ST_UPDDR, ST_SELIR, ST_CAPIR, ST_SHIR,  ST_EX1IR, ST_PAUIR, ST_EX2IR, ST_UPDIR
  } tap_st_t;

  localparam logic [3:0] OP_EXTEST  = 4'b0000;
  localparam logic [3:0] OP_SAMPLE  = 4'b0001;
  localparam logic [3:0] OP_IDCODE  = 4'b0010;
  localparam logic [3:0] OP_SETADR  = 4'b0011;
  localparam logic [3:0] OP_WRBYTE  = 4'b0100;
  localparam logic [3:0] OP_RDBYTE  = 4'b0101;
  localparam logic [3:0] OP_SAVE    = 4'b0110;
  localparam logic [3:0] OP_RESTORE = 4'b0111;
  localparam logic [3:0] OP_CLAMP   = 4'b1000;
  localparam logic [3:0] OP_HIGHZ   = 4'b1001;
  localparam logic [3:0] OP_BYPASS  = 4'b1111;

  localparam logic [3:0] IR_CAPTURE_PAT = 4'b0001;

  // Standard sixteen-state walk, steered by TMS at each rising TCK.
  function automatic tap_st_t tap_step(tap_st_t s, logic m);
    case (s)
      ST_RESET: return m ? ST_RESET : ST_IDLE;
      ST_IDLE:  return m ? ST_SELDR : ST_IDLE;
      ST_SELDR: return m ? ST_SELIR : ST_CAPDR;
      ST_CAPDR: return m ? ST_EX1DR : ST_SHDR;
      ST_SHDR:  return m ? ST_EX1DR : ST_SHDR;
      ST_EX1DR: return m ? ST_UPDDR : ST_PAUDR;
      ST_PAUDR: return m ? ST_EX2DR : ST_PAUDR;
      ST_EX2DR: return m ? ST_UPDDR : ST_SHDR;
      ST_UPDDR: return m ? ST_SELDR : ST_IDLE;
      ST_SELIR: return m ? ST_RESET : ST_CAPIR;
      ST_CAPIR: return m ? ST_EX1IR : ST_SHIR;
      ST_SHIR:  return m ? ST_EX1IR : ST_SHIR;
      ST_EX1IR: return m ? ST_UPDIR : ST_PAUIR;
      ST_PAUIR: return m ? ST_EX2IR : ST_PAUIR;
      ST_EX2IR: return m ? ST_UPDIR : ST_SHIR;
      default:  return m ? ST_SELDR : ST_IDLE;
    endcase
  endfunction

  // Codes that touch the register file or its backing store.
  function automatic logic is_prog_op(logic [3:0] op);
    return op[3:2] == 2'b01;
  endfunction

  function automatic logic is_shift_st(tap_st_t s);
    return (s == ST_SHIR) || (s == ST_SHDR);
  endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
`timescale 1ns/1ps
module jtag_tap_fsm
  import jtag_cfg_pkg::*;
(
  input  logic    tck,
  input  logic    rst_n,
  input  logic    tms,
  output tap_st_t st
);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) st <= ST_RESET;
    else        st <= tap_step(st, tms);
  end

endmodule

// File: rtl/jtag_cfg_ir.sv
`timescale 1ns/1ps
module jtag_cfg_ir
  import jtag_cfg_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tdi,
  input  tap_st_t    st,
  input  logic       busy,
  output logic [3:0] ir,
  output logic       ir_so,
  output logic       lock_hit,
  output logic       save_req,
  output logic       restore_req
);

  logic [3:0] ir_sh;
  logic       upd_now;

  assign upd_now     = (st == ST_UPDIR);
  assign lock_hit    = upd_now && busy && is_prog_op(ir_sh);
  assign save_req    = upd_now && !lock_hit && (ir_sh == OP_SAVE);
  assign restore_req = upd_now && !lock_hit && (ir_sh == OP_RESTORE);
  assign ir_so       = ir_sh[0];

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      ir_sh <= '0;
      ir    <= OP_IDCODE;
    end else begin
      if (st == ST_CAPIR)     ir_sh <= IR_CAPTURE_PAT;
      else if (st == ST_SHIR) ir_sh <= {tdi, ir_sh[3:1]};
      if (st == ST_RESET)     ir <= OP_IDCODE;
      else if (upd_now)       ir <= lock_hit ? OP_BYPASS : ir_sh;
    end
  end

endmodule

// File: rtl/jtag_cfg_dr.sv
`timescale 1ns/1ps
module jtag_cfg_dr
  import jtag_cfg_pkg::*;
#(
  parameter int          AW  = 8,
  parameter int          DW  = 8,
  parameter logic [31:0] IDV = 32'h0000_0001
)(
  input  logic          tck,
  input  logic          rst_n,
  input  logic          tdi,
  input  tap_st_t       st,
  input  logic [3:0]    ir,
  input  logic [DW-1:0] rf_rdata,
  input  logic          bs_so,
  output logic          dr_so,
  output logic [AW-1:0] rf_addr,
  output logic [DW-1:0] rf_wdata,
  output logic          rf_we,
  output logic          addr_step,
  output logic          bs_capture,
  output logic          bs_shift,
  output logic          bs_update,
  output logic          pins_drive,
  output logic          pins_hiz
);

  localparam int IDW = 32;

  logic sel_id, sel_adr, sel_wr, sel_rd, sel_byte, sel_bs;
  logic          byp;
  logic [IDW-1:0] id_sh;
  logic [AW-1:0] adr_sh, adr_q;
  logic [DW-1:0] byte_sh;

  function automatic logic [AW-1:0] next_addr(logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  assign sel_id   = (ir == OP_IDCODE);
  assign sel_adr  = (ir == OP_SETADR);
  assign sel_wr   = (ir == OP_WRBYTE);
  assign sel_rd   = (ir == OP_RDBYTE);
  assign sel_byte = sel_wr || sel_rd;
  assign sel_bs   = (ir == OP_EXTEST) || (ir == OP_SAMPLE);

  assign addr_step  = (st == ST_UPDDR) && sel_byte;
  assign rf_we      = (st == ST_UPDDR) && sel_wr;
  assign rf_wdata   = byte_sh;
  assign rf_addr    = adr_q;
  assign bs_capture = (st == ST_CAPDR) && sel_bs;
  assign bs_shift   = (st == ST_SHDR)  && sel_bs;
  assign bs_update  = (st == ST_UPDDR) && sel_bs;
  assign pins_drive = (ir == OP_EXTEST) || (ir == OP_CLAMP);
  assign pins_hiz   = (ir == OP_HIGHZ);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      byp     <= 1'b0;
      id_sh   <= '0;
      adr_sh  <= '0;
      byte_sh <= '0;
      adr_q   <= '0;
    end else begin
      case (st)
        ST_CAPDR: begin
          byp <= 1'b0;
          if (sel_id)  id_sh   <= IDV;
          if (sel_adr) adr_sh  <= adr_q;
          if (sel_rd)  byte_sh <= rf_rdata;
        end
        ST_SHDR: begin
          byp <= tdi;
          if (sel_id)   id_sh   <= {tdi, id_sh[IDW-1:1]};
          if (sel_adr)  adr_sh  <= {tdi, adr_sh[AW-1:1]};
          if (sel_byte) byte_sh <= {tdi, byte_sh[DW-1:1]};
        end
        ST_UPDDR: begin
          if (sel_adr)        adr_q <= adr_sh;
          else if (addr_step) adr_q <= next_addr(adr_q);
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    if (sel_id)        dr_so = id_sh[0];
    else if (sel_adr)  dr_so = adr_sh[0];
    else if (sel_byte) dr_so = byte_sh[0];
    else if (sel_bs)   dr_so = bs_so;
    else               dr_so = byp;
  end

endmodule

// File: rtl/jtag_cfg_tap.sv
`timescale 1ns/1ps
module jtag_cfg_tap
  import jtag_cfg_pkg::*;
#(
  parameter int          ADDR_W = 8,
  parameter int          DATA_W = 8,
  parameter logic [31:0] IDCODE = 32'h1F3B_6A0D
)(
  input  logic              tck,
  input  logic              trst_n,
  input  logic              jtag_mode,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic              tdo_en,
  output logic [ADDR_W-1:0] rf_addr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              rf_we,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              save_req,
  output logic              restore_req,
  input  logic              busy,
  input  logic              bs_so,
  output logic              bs_capture,
  output logic              bs_shift,
  output logic              bs_update,
  output logic              pins_drive,
  output logic              pins_hiz
);

  logic       rst_n;
  tap_st_t    st;
  logic [3:0] ir;
  logic       ir_so, dr_so, lock_hit, addr_step, tdo_q;

  assign rst_n = trst_n && jtag_mode;

  jtag_tap_fsm u_fsm (
    .tck(tck), .rst_n(rst_n), .tms(tms), .st(st)
  );

  jtag_cfg_ir u_ir (
    .tck(tck), .rst_n(rst_n), .tdi(tdi), .st(st), .busy(busy),
    .ir(ir), .ir_so(ir_so), .lock_hit(lock_hit),
    .save_req(save_req), .restore_req(restore_req)
  );

  jtag_cfg_dr #(.AW(ADDR_W), .DW(DATA_W), .IDV(IDCODE)) u_dr (
    .tck(tck), .rst_n(rst_n), .tdi(tdi), .st(st), .ir(ir),
    .rf_rdata(rf_rdata), .bs_so(bs_so), .dr_so(dr_so),
    .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_we(rf_we), .addr_step(addr_step),
    .bs_capture(bs_capture), .bs_shift(bs_shift), .bs_update(bs_update),
    .pins_drive(pins_drive), .pins_hiz(pins_hiz)
  );

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo_q  <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= is_shift_st(st);
      tdo_q  <= (st == ST_SHIR) ? ir_so : dr_so;
    end
  end

  assign tdo = tdo_en ? tdo_q : 1'bz;

endmodule

// File: rtl/jtag_cfg_tap_chk.sv
`timescale 1ns/1ps
module jtag_cfg_tap_chk
  import jtag_cfg_pkg::*;
#(
  parameter int AW = 8
)(
  input logic          tck,
  input logic          rst_n,
  input logic          tms,
  input tap_st_t       st,
  input logic [3:0]    ir,
  input logic          lock_hit,
  input logic          addr_step,
  input logic [AW-1:0] rf_addr,
  input logic          rf_we,
  input logic          save_req,
  input logic          restore_req,
  input logic          busy,
  input logic          tdo_en
);

  logic [2:0] hi_run;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)              hi_run <= '0;
    else if (!tms)           hi_run <= '0;
    else if (hi_run != 3'd5) hi_run <= hi_run + 3'd1;
  end

  // R2
  five_high_reset_chk: assert property (@(posedge tck) disable iff (!rst_n)
    hi_run == 3'd5 |-> st == ST_RESET);

  // R1
  reset_loads_id_chk: assert property (@(posedge tck) disable iff (!rst_n)
    st == ST_RESET |=> ir == OP_IDCODE);

  // R8
  addr_advance_chk: assert property (@(posedge tck) disable iff (!rst_n)
    addr_step |=> rf_addr == AW'($past(rf_addr) + 1'b1));

  // R10
  lock_to_bypass_chk: assert property (@(posedge tck) disable iff (!rst_n)
    lock_hit |=> ir == OP_BYPASS);

  // R10
  busy_no_request_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (busy && st == ST_UPDIR) |-> !(save_req || restore_req));

  // R9
  one_strobe_chk: assert property (@(posedge tck) disable iff (!rst_n)
    $onehot0({save_req, restore_req, rf_we}));

  // R13
  drive_in_shift_chk: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_en == (st == ST_SHIR || st == ST_SHDR));

endmodule

bind jtag_cfg_tap jtag_cfg_tap_chk #(.AW(ADDR_W)) u_chk (
  .tck(tck), .rst_n(rst_n), .tms(tms), .st(st), .ir(ir),
  .lock_hit(lock_hit), .addr_step(addr_step), .rf_addr(rf_addr),
  .rf_we(rf_we), .save_req(save_req), .restore_req(restore_req),
  .busy(busy), .tdo_en(tdo_en)
);

// File: tb/tb_jtag_cfg_tap.sv
`timescale 1ns/1ps
module tb_jtag_cfg_tap;

  localparam logic [31:0] IDV = 32'h2C5A_91E7;
  // model state numbering (bench-local)
  localparam int M_TLR = 0, M_RTI = 1, M_SDR = 2, M_CDR = 3, M_SHD = 4, M_E1D = 5,
                 M_PDR = 6, M_E2D = 7, M_UDR = 8, M_SIR = 9, M_CIR = 10, M_SHI = 11,
                 M_E1I = 12, M_PIR = 13, M_E2I = 14, M_UIR = 15;

  logic tck = 0, trst_n = 0, jtag_mode = 1, tms = 1, tdi = 0, busy = 0, bs_so = 0;
  logic tdo, tdo_en, rf_we, save_req, restore_req;
  logic bs_capture, bs_shift, bs_update, pins_drive, pins_hiz;
  logic [3:0] rf_addr;
  logic [7:0] rf_wdata, rf_rdata;
  logic [7:0] mem [16];

  int checks = 0, errors = 0, save_cnt = 0, restore_cnt = 0;

  // model
  int         m_st, m_addr;
  logic [3:0] m_ir, m_irsh, m_ash;
  logic [31:0] m_id;
  logic [7:0] m_dsh;
  logic       m_byp, bs_at_neg, last_tdo, bs_drv;
  logic [7:0] m_mem [16];

  always #10 tck = ~tck;

  jtag_cfg_tap #(.ADDR_W(4), .DATA_W(8), .IDCODE(IDV)) dut (
    .tck(tck), .trst_n(trst_n), .jtag_mode(jtag_mode), .tms(tms), .tdi(tdi),
    .tdo(tdo), .tdo_en(tdo_en), .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_we(rf_we),
    .rf_rdata(rf_rdata), .save_req(save_req), .restore_req(restore_req), .busy(busy),
    .bs_so(bs_so), .bs_capture(bs_capture), .bs_shift(bs_shift), .bs_update(bs_update),
    .pins_drive(pins_drive), .pins_hiz(pins_hiz)
  );

  assign rf_rdata = mem[rf_addr];
  always @(posedge tck) begin
    if (rf_we) mem[rf_addr] <= rf_wdata;
    if (save_req) save_cnt++;
    if (restore_req) restore_cnt++;
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  function automatic int mnext(int s, logic t);
    int r;
    case (s)
      M_TLR: r = t ? M_TLR : M_RTI;
      M_RTI, M_UDR, M_UIR: r = t ? M_SDR : M_RTI;
      M_SDR: r = t ? M_SIR : M_CDR;
      M_CDR, M_SHD: r = t ? M_E1D : M_SHD;
      M_E1D: r = t ? M_UDR : M_PDR;
      M_PDR: r = t ? M_E2D : M_PDR;
      M_E2D: r = t ? M_UDR : M_SHD;
      M_SIR: r = t ? M_TLR : M_CIR;
      M_CIR, M_SHI: r = t ? M_E1I : M_SHI;
      M_E1I: r = t ? M_UIR : M_PIR;
      M_PIR: r = t ? M_E2I : M_PIR;
      default: r = t ? M_UIR : M_SHI;
    endcase
    return r;
  endfunction

  function automatic string path_tag(logic [3:0] op);
    case (op)
      4'd0, 4'd1: return "R12 boundary path";
      4'd2: return "R4 id path";
      4'd3: return "R5 address path";
      4'd4, 4'd5: return "R7 byte path";
      default: return "R11 bypass path";
    endcase
  endfunction

  function automatic logic dr_lsb();
    case (m_ir)
      4'd0, 4'd1: return bs_at_neg;
      4'd2: return m_id[0];
      4'd3: return m_ash[0];
      4'd4, 4'd5: return m_dsh[0];
      default: return m_byp;
    endcase
  endfunction

  task automatic model_reset();
    m_st = M_TLR; m_ir = 4'd2; m_addr = 0;
  endtask

  task automatic model_step(input logic t, input logic d);
    case (m_st)
      M_TLR: m_ir = 4'd2;
      M_CIR: m_irsh = 4'b0001;
      M_SHI: m_irsh = {d, m_irsh[3:1]};
      M_UIR: m_ir = (busy && m_irsh >= 4'd4 && m_irsh <= 4'd7) ? 4'hF : m_irsh;
      M_CDR: begin
        m_byp = 1'b0;
        if (m_ir == 4'd2) m_id = IDV;
        if (m_ir == 4'd3) m_ash = 4'(m_addr);
        if (m_ir == 4'd5) m_dsh = m_mem[m_addr];
      end
      M_SHD: begin
        m_byp = d;
        if (m_ir == 4'd2) m_id = {d, m_id[31:1]};
        if (m_ir == 4'd3) m_ash = {d, m_ash[3:1]};
        if (m_ir == 4'd4 || m_ir == 4'd5) m_dsh = {d, m_dsh[7:1]};
      end
      M_UDR: begin
        if (m_ir == 4'd3) m_addr = int'(m_ash);
        if (m_ir == 4'd4) m_mem[m_addr] = m_dsh;
        if (m_ir == 4'd4 || m_ir == 4'd5) m_addr = (m_addr + 1) % 16;
      end
      default: ;
    endcase
    m_st = mnext(m_st, t);
  endtask

  task automatic compare();
    logic en, bsm;
    en  = (m_st == M_SHI || m_st == M_SHD);
    bsm = (m_ir == 4'd0 || m_ir == 4'd1);
    last_tdo = tdo;
    check("R13 tdo_en", {31'b0, tdo_en}, {31'b0, en});
    if (!en) check("R13 tdo idle", {31'b0, tdo}, {31'b0, 1'bz});
    else if (m_st == M_SHI) check("R3 ir shift", {31'b0, tdo}, {31'b0, m_irsh[0]});
    else check(path_tag(m_ir), {31'b0, tdo}, {31'b0, dr_lsb()});
    check("R6 rf_we", {31'b0, rf_we}, {31'b0, (m_st == M_UDR && m_ir == 4'd4)});
    if (rf_we) check("R6 rf_wdata", {24'b0, rf_wdata}, {24'b0, m_dsh});
    check("R8 rf_addr", {28'b0, rf_addr}, 32'(m_addr));
    check("R9 save_req", {31'b0, save_req},
          {31'b0, (m_st == M_UIR && m_irsh == 4'd6 && !busy)});
    check("R9 restore_req", {31'b0, restore_req},
          {31'b0, (m_st == M_UIR && m_irsh == 4'd7 && !busy)});
    check("R12 bs strobes", {29'b0, bs_capture, bs_shift, bs_update},
          {29'b0, bsm && m_st == M_CDR, bsm && m_st == M_SHD, bsm && m_st == M_UDR});
    check("R12 pin modes", {30'b0, pins_drive, pins_hiz},
          {30'b0, (m_ir == 4'd0 || m_ir == 4'd8), m_ir == 4'd9});
  endtask

  task automatic tick(input logic t, input logic d);
    @(negedge tck);
    bs_at_neg = bs_so;
    #1; tms = t; tdi = d; bs_so = bs_drv;
    #8; compare();
    @(posedge tck); #1;
    model_step(t, d);
  endtask

  task automatic hard_reset(input logic via_mode);
    @(negedge tck); #1;
    if (via_mode) jtag_mode = 0; else trst_n = 0;
    tms = 1; model_reset();
    #8; compare();
    check("R1 no drive in reset", {31'b0, tdo_en}, 32'd0);
    check("R1 addr cleared", {28'b0, rf_addr}, 32'd0);
    @(negedge tck); #1; trst_n = 1; jtag_mode = 1;
    #8; compare();
    @(posedge tck); #1; model_step(1'b1, tdi);
  endtask

  task automatic load_ir(input logic [3:0] v);
    logic [3:0] cap;
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 4; i++) begin
      tick(i == 3, v[i]);
      cap[i] = last_tdo;
    end
    check("R3 capture pattern", {28'b0, cap}, 32'd1);
    tick(1, 0); tick(0, 0);
  endtask

  task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
    dout = '0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, din[i]);
      dout[i] = last_tdo;
    end
    tick(1, 0); tick(0, 0);
  endtask

  initial begin
    #(20 * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    bs_drv = 0; bs_at_neg = 0; last_tdo = 0;
    m_irsh = '0; m_ash = '0; m_dsh = '0; m_id = '0; m_byp = 0;
    for (int i = 0; i < 16; i++) begin
      mem[i] = 8'(i * 17);
      m_mem[i] = 8'(i * 17);
    end
    model_reset();
    hard_reset(0);
    tick(0, 0);
    scan_dr(32, 32'h0, d);                  check("R4 idcode after reset", d, IDV);

    load_ir(4'd3); scan_dr(4, 32'd3, d);     check("R5 address capture", d, 32'd0);
    load_ir(4'd4); scan_dr(8, 32'hA5, d); scan_dr(8, 32'h3C, d);
    check("R6 byte written", {24'b0, mem[3]}, 32'hA5);
    check("R8 next byte written", {24'b0, mem[4]}, 32'h3C);
    load_ir(4'd3); scan_dr(4, 32'd3, d);     check("R8 address after writes", d, 32'd5);
    load_ir(4'd5); scan_dr(8, 32'h0, d);     check("R7 byte read", d, 32'hA5);
    scan_dr(8, 32'h0, d);                    check("R8 read advances", d, 32'h3C);

    load_ir(4'd3); scan_dr(4, 32'd15, d);
    load_ir(4'd4); scan_dr(8, 32'hA1, d); scan_dr(8, 32'hB2, d);
    check("R8 top address", {24'b0, mem[15]}, 32'hA1);
    check("R8 wrap to zero", {24'b0, mem[0]}, 32'hB2);

    load_ir(4'hF); scan_dr(8, 32'hB6, d);    check("R11 bypass delay", d, 32'h6C);
    load_ir(4'hA); scan_dr(8, 32'hB6, d);    check("R11 unused code", d, 32'h6C);
    load_ir(4'h8); check("R12 clamp drives", {31'b0, pins_drive}, 32'd1);
    scan_dr(8, 32'hB6, d);                   check("R11 clamp bypass", d, 32'h6C);
    load_ir(4'h9); check("R12 highz", {31'b0, pins_hiz}, 32'd1);
    load_ir(4'h0); bs_drv = 1; scan_dr(8, 32'h0, d); bs_drv = 0;
    check("R12 boundary data", d, 32'hFF);

    load_ir(4'd6);
    check("R9 one save request", 32'(save_cnt), 32'd1);
    scan_dr(8, 32'hB6, d);                   check("R9 save uses bypass", d, 32'h6C);

    busy = 1;
    load_ir(4'd4); scan_dr(8, 32'hB6, d);    check("R10 write locked out", d, 32'h6C);
    load_ir(4'd7);
    check("R10 restore ignored", 32'(restore_cnt), 32'd0);
    load_ir(4'd2); scan_dr(32, 32'h0, d);    check("R10 idcode while busy", d, IDV);
    busy = 0;
    load_ir(4'd7);
    check("R9 one restore request", 32'(restore_cnt), 32'd1);

    load_ir(4'hF);
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 5; i++) tick(1, 0);
    check("R2 idle after five", {31'b0, tdo_en}, 32'd0);
    tick(0, 0);
    scan_dr(32, 32'h0, d);                   check("R2 idcode restored", d, IDV);

    load_ir(4'hF);
    hard_reset(1);
    tick(0, 0);
    scan_dr(32, 32'h0, d);                   check("R1 mode switch reset", d, IDV);

    for (int i = 0; i < 16; i++)
      check("R6 file contents", {24'b0, mem[i]}, {24'b0, m_mem[i]});

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule